// File: doc/BRIEF.md
# Vector Halfword Element Store Unit

This block executes a single-element vector store of one halfword. An issued instruction arrives with a 128-bit source vector, two 64-bit general-register values, the program counter and a flag that says the base register field is zero. The block checks the encoding and forms a 32-bit effective address. It picks the halfword lane that the address names and places that lane, big-endian, into a 16-byte memory write with exactly two byte enables set.

When the reservation mechanism reports active holders, the same memory transaction also carries an invalidate request for the aligned store address. Completion is reported with a one-cycle pulse together with the next program counter. An encoding that is not this store completes at once with an illegal flag and never touches memory. Both the issue side and the memory side use a valid/ready handshake. Every output is a register.

Top module: `vhst_unit`

## Requirements
- R1: An instruction is accepted as the store only when iss_insn[31:26] equals 31 and iss_insn[10:1] equals 167. Any other word completes with done and illegal both high in the cycle after acceptance, issues no memory write, and reports next_pc equal to the issued PC.
- R2: When iss_ra_zero is high, the base value is zero whatever iss_ra_val holds.
- R3: The effective address (EA) is the low 32 bits of base plus iss_rb_val, wrapping on overflow.
- R4: mem_addr equals EA with bit 0 cleared.
- R5: The lane index is EA[3:1]. Vector byte 0 is iss_vec[127:120], and lane k is vector bytes 2k and 2k+1.
- R6: Line byte j is carried on mem_wdata[127-8j -: 8] and enabled by mem_be[15-j]. Exactly two enables are set, for bytes 2*EA[3:1] and 2*EA[3:1]+1. All data bits outside those two bytes are zero.
- R7: The byte at the lower line offset holds the most significant byte of the selected lane.
- R8: If resv_active is high at acceptance, mem_inv_valid is high with mem_inv_addr equal to mem_addr for as long as mem_valid is high. Otherwise mem_inv_valid stays low.
- R9: For an accepted store, next_pc equals the issued PC plus 4 while done is high.
- R10: iss_ready is high only when the unit is idle. mem_valid rises in the cycle after an accepted store, and iss_ready stays low until done has been reported.
- R11: done is a one-cycle pulse. It rises in the cycle after the memory handshake.
- R12: While mem_valid is high and mem_ready is low, mem_valid, mem_addr, mem_wdata, mem_be, mem_inv_valid and mem_inv_addr hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request valid |
| iss_ready | output | 1 | Unit idle and able to accept |
| iss_insn | input | 32 | Instruction word, bit 31 = instruction bit 0 |
| iss_pc | input | 32 | Program counter of the instruction |
| iss_vec | input | 128 | Source vector, byte 0 in bits 127:120 |
| iss_ra_val | input | 64 | Base register value |
| iss_rb_val | input | 64 | Index register value |
| iss_ra_zero | input | 1 | Base register field is zero, so the base is 0 |
| resv_active | input | 1 | Reservation tracking enabled with active holders |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 32 | Halfword-aligned store address |
| mem_wdata | output | 128 | Line-positioned write data |
| mem_be | output | 16 | Byte enables, bit 15 = line byte 0 |
| mem_inv_valid | output | 1 | Reservation invalidate request |
| mem_inv_addr | output | 32 | Address to invalidate |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Completion was a rejected encoding |
| next_pc | output | 32 | Next program counter, valid with done |

## Verification
The hardest cases to reach from the ports are an odd effective address that also wraps past 2^32, and a memory request held while mem_ready stays low. The first changes the lane and the aligned address together. The second shows whether the request registers drift. The bench builds addresses from base and index pairs whose sums carry out of 32 bits and have bit 0 set, and sweeps all eight lanes that way. It also withholds mem_ready for several cycles on stores with the reservation flag both set and clear, and compares every request field against its value on the first cycle.

// File: rtl/vhst_pkg.sv
package vhst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEM  = 2'd1,
    ST_FIN  = 2'd2
  } vhst_state_e;

  localparam int unsigned OPC_PRIMARY = 31;
  localparam int unsigned OPC_EXT     = 167;
endpackage

// File: rtl/vhst_decode.sv
module vhst_decode #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned AW   = 32,
  parameter int unsigned PRIM = 31,
  parameter int unsigned EXT  = 167
) (
  input  logic [31:0]     insn,
  input  logic [XLEN-1:0] ra_val,
  input  logic [XLEN-1:0] rb_val,
  input  logic            ra_zero,
  output logic            legal,
  output logic [AW-1:0]   ea
);
  localparam logic [5:0] PRIM_C = 6'(PRIM);
  localparam logic [9:0] EXT_C  = 10'(EXT);

  logic [AW-1:0] base;
  logic [5:0]    f_prim;
  logic [9:0]    f_ext;

  assign f_prim = insn[31:26];
  assign f_ext  = insn[10:1];
  assign legal  = (f_prim == PRIM_C) && (f_ext == EXT_C);

  // Only the low AW bits of the sum are kept, so the upper bits cannot matter.
  assign base = ra_zero ? '0 : ra_val[AW-1:0];
  assign ea   = base + rb_val[AW-1:0];

  logic unused_bits;
  assign unused_bits = ^{insn[25:11], insn[0], ra_val[XLEN-1:AW], rb_val[XLEN-1:AW]};
endmodule

// File: rtl/vhst_lane_pick.sv
module vhst_lane_pick #(
  parameter int unsigned AW         = 32,
  parameter int unsigned VBYTES     = 16,
  parameter int unsigned ELEM_BYTES = 2
) (
  input  logic [AW-1:0]         ea,
  input  logic [VBYTES*8-1:0]   vec,
  output logic [AW-1:0]         addr_al,
  output logic [VBYTES*8-1:0]   wdata,
  output logic [VBYTES-1:0]     be
);
  localparam int unsigned VBITS  = VBYTES * 8;
  localparam int unsigned EBITS  = ELEM_BYTES * 8;
  localparam int unsigned NLANES = VBYTES / ELEM_BYTES;
  localparam int unsigned EOFF_W = (ELEM_BYTES > 1) ? $clog2(ELEM_BYTES) : 1;
  localparam int unsigned VOFF_W = $clog2(VBYTES);
  localparam int unsigned LIDX_W = (NLANES > 1) ? $clog2(NLANES) : 1;
  localparam logic [AW-1:0] AL_MASK = ~(AW'(ELEM_BYTES) - AW'(1));

  logic [LIDX_W-1:0] lane;

  if (NLANES > 1) begin : g_multi
    if (ELEM_BYTES > 1) begin : g_wide
      assign lane = ea[VOFF_W-1:EOFF_W];
    end else begin : g_byte
      assign lane = ea[VOFF_W-1:0];
    end
  end else begin : g_single
    assign lane = '0;
  end

  assign addr_al = ea & AL_MASK;

  // Each lane drives its own slice; only the addressed lane passes data.
  for (genvar k = 0; k < NLANES; k++) begin : g_lane
    logic hit;
    assign hit = (lane == LIDX_W'(k));
    assign wdata[VBITS-1-k*EBITS -: EBITS] =
      hit ? vec[VBITS-1-k*EBITS -: EBITS] : '0;
    assign be[VBYTES-1-k*ELEM_BYTES -: ELEM_BYTES] = {ELEM_BYTES{hit}};
  end

  logic unused_ea;
  if (VOFF_W < AW) begin : g_hi
    assign unused_ea = ^ea[AW-1:VOFF_W];
  end else begin : g_nohi
    assign unused_ea = 1'b0;
  end
endmodule

// File: rtl/vhst_unit.sv
module vhst_unit #(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned AW         = 32,
  parameter int unsigned VBYTES     = 16,
  parameter int unsigned ELEM_BYTES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  iss_valid,
  output logic                  iss_ready,
  input  logic [31:0]           iss_insn,
  input  logic [AW-1:0]         iss_pc,
  input  logic [VBYTES*8-1:0]   iss_vec,
  input  logic [XLEN-1:0]       iss_ra_val,
  input  logic [XLEN-1:0]       iss_rb_val,
  input  logic                  iss_ra_zero,
  input  logic                  resv_active,
  output logic                  mem_valid,
  input  logic                  mem_ready,
  output logic [AW-1:0]         mem_addr,
  output logic [VBYTES*8-1:0]   mem_wdata,
  output logic [VBYTES-1:0]     mem_be,
  output logic                  mem_inv_valid,
  output logic [AW-1:0]         mem_inv_addr,
  output logic                  done,
  output logic                  illegal,
  output logic [AW-1:0]         next_pc
);
  import vhst_pkg::*;

  localparam int unsigned VBITS = VBYTES * 8;

  vhst_state_e state;
  logic [AW-1:0]    pc_q;
  logic             dec_legal;
  logic [AW-1:0]    dec_ea;
  logic [AW-1:0]    sel_addr;
  logic [VBITS-1:0] sel_data;
  logic [VBYTES-1:0] sel_be;

  vhst_decode #(
    .XLEN (XLEN),
    .AW   (AW),
    .PRIM (OPC_PRIMARY),
    .EXT  (OPC_EXT)
  ) u_decode (
    .insn    (iss_insn),
    .ra_val  (iss_ra_val),
    .rb_val  (iss_rb_val),
    .ra_zero (iss_ra_zero),
    .legal   (dec_legal),
    .ea      (dec_ea)
  );

  vhst_lane_pick #(
    .AW         (AW),
    .VBYTES     (VBYTES),
    .ELEM_BYTES (ELEM_BYTES)
  ) u_lane (
    .ea      (dec_ea),
    .vec     (iss_vec),
    .addr_al (sel_addr),
    .wdata   (sel_data),
    .be      (sel_be)
  );

  assign iss_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      pc_q          <= '0;
      mem_valid     <= 1'b0;
      mem_addr      <= '0;
      mem_wdata     <= '0;
      mem_be        <= '0;
      mem_inv_valid <= 1'b0;
      mem_inv_addr  <= '0;
      done          <= 1'b0;
      illegal       <= 1'b0;
      next_pc       <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (iss_valid) begin
            pc_q <= iss_pc;
            if (dec_legal) begin
              state         <= ST_MEM;
              mem_valid     <= 1'b1;
              mem_addr      <= sel_addr;
              mem_wdata     <= sel_data;
              mem_be        <= sel_be;
              mem_inv_valid <= resv_active;
              mem_inv_addr  <= sel_addr;
            end else begin
              state   <= ST_FIN;
              done    <= 1'b1;
              illegal <= 1'b1;
              next_pc <= iss_pc;
            end
          end
        end
        ST_MEM: begin
          if (mem_ready) begin
            state         <= ST_FIN;
            mem_valid     <= 1'b0;
            mem_inv_valid <= 1'b0;
            done          <= 1'b1;
            next_pc       <= pc_q + AW'(4);
          end
        end
        default: begin
          state   <= ST_IDLE;
          done    <= 1'b0;
          illegal <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/vhst_unit_chk.sv
module vhst_unit_chk #(
  parameter int unsigned AW     = 32,
  parameter int unsigned VBYTES = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                iss_valid,
  input logic                iss_ready,
  input logic                mem_valid,
  input logic                mem_ready,
  input logic [AW-1:0]       mem_addr,
  input logic [VBYTES*8-1:0] mem_wdata,
  input logic [VBYTES-1:0]   mem_be,
  input logic                mem_inv_valid,
  input logic [AW-1:0]       mem_inv_addr,
  input logic                done,
  input logic                illegal
);
  p_illegal_nomem_r1: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (done && !mem_valid));

  p_aligned_r4: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_addr[0] == 1'b0));

  p_two_bytes_r6: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> ($countones(mem_be) == 2));

  p_inv_match_r8: assert property (@(posedge clk) disable iff (rst)
    mem_inv_valid |-> (mem_valid && (mem_inv_addr == mem_addr)));

  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_ready) |=> !iss_ready);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_after_hs_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready) |=> (done && !mem_valid));

  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
      $stable(mem_wdata) && $stable(mem_be) && $stable(mem_inv_valid) &&
      $stable(mem_inv_addr)));
endmodule

bind vhst_unit vhst_unit_chk #(.AW(AW), .VBYTES(VBYTES)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .iss_valid     (iss_valid),
  .iss_ready     (iss_ready),
  .mem_valid     (mem_valid),
  .mem_ready     (mem_ready),
  .mem_addr      (mem_addr),
  .mem_wdata     (mem_wdata),
  .mem_be        (mem_be),
  .mem_inv_valid (mem_inv_valid),
  .mem_inv_addr  (mem_inv_addr),
  .done          (done),
  .illegal       (illegal)
);

// File: tb/vhst_unit_tb.sv
module vhst_unit_tb;
  localparam logic [31:0] INSN_OK = 32'h7C64_A14E;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         iss_valid = 1'b0;
  logic         iss_ready;
  logic [31:0]  iss_insn = '0;
  logic [31:0]  iss_pc = '0;
  logic [127:0] iss_vec = '0;
  logic [63:0]  iss_ra_val = '0;
  logic [63:0]  iss_rb_val = '0;
  logic         iss_ra_zero = 1'b0;
  logic         resv_active = 1'b0;
  logic         mem_valid;
  logic         mem_ready = 1'b0;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic [15:0]  mem_be;
  logic         mem_inv_valid;
  logic [31:0]  mem_inv_addr;
  logic         done;
  logic         illegal;
  logic [31:0]  next_pc;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  vhst_unit u_dut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_insn(iss_insn), .iss_pc(iss_pc), .iss_vec(iss_vec),
    .iss_ra_val(iss_ra_val), .iss_rb_val(iss_rb_val), .iss_ra_zero(iss_ra_zero),
    .resv_active(resv_active), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_inv_valid(mem_inv_valid), .mem_inv_addr(mem_inv_addr),
    .done(done), .illegal(illegal), .next_pc(next_pc)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Issue one legal store, hold mem_ready low for `stall` cycles, check everything.
  task automatic run_store(input string tag, input logic [63:0] ra, input logic [63:0] rb,
                           input bit raz, input bit resv, input logic [127:0] vec,
                           input logic [31:0] pc, input int stall);
    logic [31:0]  ea, exp_addr;
    logic [127:0] exp_data;
    logic [15:0]  exp_be;
    int           lane;
    ea        = (raz ? 32'h0 : ra[31:0]) + rb[31:0];
    exp_addr  = {ea[31:1], 1'b0};
    lane      = int'(ea[3:1]);
    exp_data  = '0;
    exp_data[127-16*lane -: 16] = vec[127-16*lane -: 16];
    exp_be    = '0;
    exp_be[15-2*lane] = 1'b1;
    exp_be[14-2*lane] = 1'b1;

    @(negedge clk);
    iss_valid = 1'b1; iss_insn = INSN_OK; iss_pc = pc; iss_vec = vec;
    iss_ra_val = ra; iss_rb_val = rb; iss_ra_zero = raz; resv_active = resv;
    @(negedge clk);
    iss_valid = 1'b0;
    iss_ra_val = ~ra; iss_rb_val = ~rb; iss_vec = ~vec; resv_active = ~resv;
    chk(mem_valid == 1'b1, "R10", {tag, " mem_valid after accept"}, 128'(mem_valid), 128'd1);
    chk(iss_ready == 1'b0, "R10", {tag, " busy"}, 128'(iss_ready), 128'd0);
    chk(mem_addr == exp_addr, "R3 R4", {tag, " address"}, 128'(mem_addr), 128'(exp_addr));
    chk(mem_wdata == exp_data, "R5 R7", {tag, " lane data"}, mem_wdata, exp_data);
    chk(mem_be == exp_be, "R6", {tag, " byte enables"}, 128'(mem_be), 128'(exp_be));
    chk(mem_inv_valid == resv, "R8", {tag, " invalidate valid"}, 128'(mem_inv_valid), 128'(resv));
    if (resv)
      chk(mem_inv_addr == exp_addr, "R8", {tag, " invalidate addr"}, 128'(mem_inv_addr), 128'(exp_addr));
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(mem_valid && mem_addr == exp_addr && mem_wdata == exp_data && mem_be == exp_be
          && mem_inv_valid == resv && done == 1'b0, "R12", {tag, " hold"},
          {mem_wdata}, exp_data);
    end
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
    chk(done == 1'b1 && illegal == 1'b0, "R11", {tag, " done"}, 128'({done, illegal}), 128'b10);
    chk(mem_valid == 1'b0 && mem_inv_valid == 1'b0, "R8", {tag, " request dropped"},
        128'({mem_valid, mem_inv_valid}), 128'd0);
    chk(next_pc == pc + 32'd4, "R9", {tag, " next_pc"}, 128'(next_pc), 128'(pc + 32'd4));
    @(negedge clk);
    chk(done == 1'b0 && iss_ready == 1'b1, "R11", {tag, " pulse ends"},
        128'({done, iss_ready}), 128'b01);
  endtask

  task automatic run_illegal(input string tag, input logic [31:0] insn, input logic [31:0] pc);
    @(negedge clk);
    iss_valid = 1'b1; iss_insn = insn; iss_pc = pc; resv_active = 1'b1;
    iss_ra_val = 64'h10; iss_rb_val = 64'h4;
    @(negedge clk);
    iss_valid = 1'b0;
    chk(done && illegal, "R1", {tag, " illegal done"}, 128'({done, illegal}), 128'b11);
    chk(!mem_valid && !mem_inv_valid, "R1", {tag, " no memory"},
        128'({mem_valid, mem_inv_valid}), 128'd0);
    chk(next_pc == pc, "R1", {tag, " pc kept"}, 128'(next_pc), 128'(pc));
    @(negedge clk);
    chk(!done && !illegal && iss_ready && !mem_valid, "R1", {tag, " back to idle"},
        128'({done, illegal, iss_ready, mem_valid}), 128'b0010);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(iss_ready && !mem_valid && !done && !illegal && !mem_inv_valid, "R10", "reset state",
        128'({iss_ready, mem_valid, done, illegal, mem_inv_valid}), 128'b10000);
  endtask

  task automatic test_lane_sweep();
    for (int k = 0; k < 8; k++) begin
      // Odd address that carries past 2^32: R3 wrap, R4 align, R5 lane choice.
      run_store($sformatf("sweep lane %0d", k), 64'hFFFF_FFFF_FFFF_FFF0,
                64'h0000_0000_0000_0021 + 64'(2*k), 1'b0, k[0],
                128'h0102_1112_2122_3132_4142_5152_6162_7172, 32'h100 + 32'(8*k), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    test_reset();
    run_store("R2 base zero", 64'hDEAD_BEEF_0000_1234, 64'h0000_0000_8000_0006, 1'b1, 1'b0,
              128'hA0A1_B0B1_C0C1_D0D1_E0E1_F0F1_0A0B_1C1D, 32'h2000, 0);
    run_store("R3 wrap", 64'hFFFF_FFFF_FFFF_FFFE, 64'h0000_0000_0000_000A, 1'b0, 1'b1,
              128'h1111_2222_3333_4444_5555_6666_7777_8888, 32'hFFFF_FFFC, 0);
    test_lane_sweep();
    run_store("R12 stall resv", 64'h0000_0000_1000_0000, 64'h0000_0000_0000_000D, 1'b0, 1'b1,
              128'hCAFE_F00D_1234_5678_9ABC_DEF0_0F1E_2D3C, 32'h4000, 4);
    run_store("R12 stall plain", 64'h0000_0000_2000_0001, 64'h0000_0000_0000_0000, 1'b0, 1'b0,
              128'hFEDC_BA98_7654_3210_0123_4567_89AB_CDEF, 32'h4010, 3);
    run_illegal("R1 bad ext", 32'h7C00_010E, 32'h5000);
    run_illegal("R1 bad primary", 32'h7800_014E, 32'h5004);
    run_store("R10 after illegal", 64'h40, 64'h3, 1'b0, 1'b0,
              128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 32'h5008, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule